// File: doc/BRIEF.md
# Control/bulk list service-ratio arbiter

This block decides which endpoint list a USB host controller should serve next inside a frame. Periodic traffic is served first. It is gated by an enable bit that is captured only on the start-of-frame strobe, so software writes to that bit take effect from the following frame.

When periodic work is not being served, the arbiter moves between the control list and the bulk list according to a 2-bit service ratio. A saturating count of non-empty control descriptors drives this choice. The count is kept across frame boundaries. Once it passes the ratio, one bulk descriptor is served and the count starts again from zero.

The descriptor engine reports each finished descriptor with a done strobe, the list it belonged to and whether it carried data. The engine then reads the selected list from the output, which is combinational from the arbiter state and the current work flags.

Top module: `usb_list_arbiter`

## Requirements
- R1: After reset the count is 0, the captured periodic enable is off and control is the preferred list.
- R2: The ratio field gives the control-to-bulk service ratio (value r means r+1 control descriptors per bulk descriptor, so 0=1:1, 1=2:1, 2=3:1, 3=4:1). Once r+1 non-empty control descriptors have completed, bulk becomes the preferred list.
- R3: A control done strobe with the non-empty flag low leaves the count unchanged.
- R4: A bulk done strobe while bulk is preferred clears the count to 0, which makes control preferred again.
- R5: The start-of-frame strobe does not change the count.
- R6: The periodic enable input is captured only on a start-of-frame strobe. The periodic list (code 3) is served when the captured enable is set and periodic work is flagged. A change of the input between strobes has no effect.
- R7: If the preferred list has no work, the other non-periodic list is served if it has work. Otherwise the output is idle (code 0).
- R8: A done strobe whose list code is periodic (3) or idle (0) leaves the count unchanged.
- R9: Output codes are 0 idle, 1 control, 2 bulk, 3 periodic. The same codes are used for the done strobe's list input.
- R10: Fallback service moves no count. A bulk done while control is preferred leaves the count alone. A non-empty control done while bulk is preferred does not advance the count further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_i | input | 1 | Start-of-frame strobe |
| periodic_en_i | input | 1 | Periodic list enable, captured at start of frame |
| ratio_i | input | RATIO_W | Control-to-bulk service ratio |
| ed_done_i | input | 1 | Descriptor completion strobe |
| ed_kind_i | input | 2 | List code of the completed descriptor |
| ed_nonempty_i | input | 1 | Completed descriptor carried data |
| ctrl_work_i | input | 1 | Control list has work |
| bulk_work_i | input | 1 | Bulk list has work |
| periodic_work_i | input | 1 | Periodic list has work |
| serve_o | output | 2 | List to serve next |

## Verification
A wrong count shows up as a control or bulk choice out of step with the ratio. With both lists busy, this is visible on the output in the first cycle after the faulty update. A captured enable that is wrong shows as periodic service that starts or stops without a start-of-frame strobe, which is also visible one cycle later. The reference model compares the selection on every clock, so any divergence is reported in the cycle it first reaches the output.

// File: rtl/usb_arb_pkg.sv
package usb_arb_pkg;
    typedef enum logic [1:0] {
        LIST_IDLE     = 2'd0,
        LIST_CTRL     = 2'd1,
        LIST_BULK     = 2'd2,
        LIST_PERIODIC = 2'd3
    } list_e;
endpackage

// File: rtl/usb_arb_ratio_ctr.sv
module usb_arb_ratio_ctr #(
    parameter int RATIO_W = 2,
    localparam int CNT_W  = RATIO_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               done_i,
    input  logic [1:0]         kind_i,
    input  logic               nonempty_i,
    output logic               prefer_bulk_o,
    output logic [CNT_W-1:0]   cnt_o
);
    import usb_arb_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t s_d, s_q;
    logic [CNT_W-1:0] limit;
    logic             bulk_turn;

    assign limit     = {1'b0, ratio_i};
    assign bulk_turn = s_q.cnt > limit;

    always_comb begin
        s_d = s_q;
        if (done_i) begin
            if (kind_i == LIST_CTRL && nonempty_i && !bulk_turn) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end else if (kind_i == LIST_BULK && bulk_turn) begin
                s_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign prefer_bulk_o = bulk_turn;
    assign cnt_o         = s_q.cnt;
endmodule

// File: rtl/usb_arb_frame_gate.sv
module usb_arb_frame_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic sof_i,
    input  logic en_i,
    output logic active_o
);
    typedef struct packed {
        logic active;
    } gate_t;

    gate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sof_i) begin
            s_d.active = en_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = s_q.active;
endmodule

// File: rtl/usb_arb_pick.sv
module usb_arb_pick (
    input  logic       periodic_on_i,
    input  logic       periodic_work_i,
    input  logic       prefer_bulk_i,
    input  logic       ctrl_work_i,
    input  logic       bulk_work_i,
    output logic [1:0] serve_o
);
    import usb_arb_pkg::*;

    list_e first, second, pick;
    logic  first_work, second_work;

    always_comb begin
        first       = prefer_bulk_i ? LIST_BULK : LIST_CTRL;
        second      = prefer_bulk_i ? LIST_CTRL : LIST_BULK;
        first_work  = prefer_bulk_i ? bulk_work_i : ctrl_work_i;
        second_work = prefer_bulk_i ? ctrl_work_i : bulk_work_i;
        if (periodic_on_i && periodic_work_i) begin
            pick = LIST_PERIODIC;
        end else if (first_work) begin
            pick = first;
        end else if (second_work) begin
            pick = second;
        end else begin
            pick = LIST_IDLE;
        end
    end

    assign serve_o = pick;
endmodule

// File: rtl/usb_list_arbiter.sv
module usb_list_arbiter #(
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof_i,
    input  logic               periodic_en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               ed_done_i,
    input  logic [1:0]         ed_kind_i,
    input  logic               ed_nonempty_i,
    input  logic               ctrl_work_i,
    input  logic               bulk_work_i,
    input  logic               periodic_work_i,
    output logic [1:0]         serve_o
);
    localparam int CNT_W = RATIO_W + 1;

    logic             prefer_bulk_w;
    logic             periodic_on_w;
    logic [CNT_W-1:0] cnt_w;

    usb_arb_ratio_ctr #(.RATIO_W(RATIO_W)) ratio_i_u (
        .clk           (clk),
        .rst_n         (rst_n),
        .ratio_i       (ratio_i),
        .done_i        (ed_done_i),
        .kind_i        (ed_kind_i),
        .nonempty_i    (ed_nonempty_i),
        .prefer_bulk_o (prefer_bulk_w),
        .cnt_o         (cnt_w)
    );

    usb_arb_frame_gate gate_u (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof_i    (sof_i),
        .en_i     (periodic_en_i),
        .active_o (periodic_on_w)
    );

    usb_arb_pick pick_u (
        .periodic_on_i   (periodic_on_w),
        .periodic_work_i (periodic_work_i),
        .prefer_bulk_i   (prefer_bulk_w),
        .ctrl_work_i     (ctrl_work_i),
        .bulk_work_i     (bulk_work_i),
        .serve_o         (serve_o)
    );
endmodule

// File: rtl/usb_list_arbiter_chk.sv
module usb_list_arbiter_chk #(
    parameter int RATIO_W = 2,
    localparam int CNT_W  = RATIO_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sof_i,
    input logic [RATIO_W-1:0] ratio_i,
    input logic               ed_done_i,
    input logic [1:0]         ed_kind_i,
    input logic               ed_nonempty_i,
    input logic               ctrl_work_i,
    input logic               bulk_work_i,
    input logic               periodic_work_i,
    input logic [1:0]         serve_o,
    input logic [CNT_W-1:0]   cnt_w,
    input logic               periodic_on_w
);
    // R7
    idle_when_no_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_work_i && !bulk_work_i && !periodic_work_i) |-> (serve_o == 2'd0));

    // R6
    periodic_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serve_o == 2'd3) |-> periodic_work_i);

    // R6
    gate_holds_between_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_i |=> $stable(periodic_on_w));

    // R3
    empty_ctrl_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ed_done_i && ed_kind_i == 2'd1 && !ed_nonempty_i) |=> $stable(cnt_w));

    // R8
    count_moves_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ed_done_i || ed_kind_i == 2'd0 || ed_kind_i == 2'd3) |=> $stable(cnt_w));

    // R4
    bulk_turn_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ed_done_i && ed_kind_i == 2'd2 && cnt_w > {1'b0, ratio_i}) |=> (cnt_w == '0));
endmodule

bind usb_list_arbiter usb_list_arbiter_chk #(.RATIO_W(RATIO_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .sof_i           (sof_i),
    .ratio_i         (ratio_i),
    .ed_done_i       (ed_done_i),
    .ed_kind_i       (ed_kind_i),
    .ed_nonempty_i   (ed_nonempty_i),
    .ctrl_work_i     (ctrl_work_i),
    .bulk_work_i     (bulk_work_i),
    .periodic_work_i (periodic_work_i),
    .serve_o         (serve_o),
    .cnt_w           (cnt_w),
    .periodic_on_w   (periodic_on_w)
);

// File: tb/usb_list_arbiter_tb.sv
`timescale 1ns/100ps
module usb_list_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sof_i = 1'b0;
    logic       periodic_en_i = 1'b0;
    logic [1:0] ratio_i = 2'd0;
    logic       ed_done_i = 1'b0;
    logic [1:0] ed_kind_i = 2'd0;
    logic       ed_nonempty_i = 1'b0;
    logic       ctrl_work_i = 1'b0;
    logic       bulk_work_i = 1'b0;
    logic       periodic_work_i = 1'b0;
    logic [1:0] serve_o;

    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt = 0;
    bit m_per = 1'b0;

    always #2.5 clk = ~clk;

    usb_list_arbiter #(.RATIO_W(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .periodic_en_i(periodic_en_i),
        .ratio_i(ratio_i), .ed_done_i(ed_done_i), .ed_kind_i(ed_kind_i),
        .ed_nonempty_i(ed_nonempty_i), .ctrl_work_i(ctrl_work_i),
        .bulk_work_i(bulk_work_i), .periodic_work_i(periodic_work_i),
        .serve_o(serve_o)
    );

    function automatic int model_pick();
        bit bulk_turn;
        bulk_turn = m_cnt > int'(ratio_i);
        if (m_per && periodic_work_i) return 3;
        if (bulk_turn) return bulk_work_i ? 2 : (ctrl_work_i ? 1 : 0);
        return ctrl_work_i ? 1 : (bulk_work_i ? 2 : 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_per = 1'b0;
        end else begin
            if (sof_i) m_per = periodic_en_i;
            if (ed_done_i) begin
                if (ed_kind_i == 2'd1 && ed_nonempty_i && m_cnt <= int'(ratio_i)) m_cnt = m_cnt + 1;
                else if (ed_kind_i == 2'd2 && m_cnt > int'(ratio_i)) m_cnt = 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // every-clock comparison against the reference
    always @(negedge clk) begin
        if (!finished) check(cur_req, int'(serve_o), model_pick());
    end

    task automatic tick();
        @(posedge clk);
        #1;
        sof_i = 1'b0;
        ed_done_i = 1'b0;
    endtask

    task automatic done(input logic [1:0] kind, input logic ne);
        ed_done_i = 1'b1;
        ed_kind_i = kind;
        ed_nonempty_i = ne;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int run;
        int s;
        // R1: reset state, control preferred, ratio 0 -> one ctrl then bulk
        cur_req = "R1";
        ctrl_work_i = 1'b1;
        bulk_work_i = 1'b1;
        repeat (3) tick();
        #1 check("R1", int'(serve_o), 1);
        rst_n = 1'b1;
        tick();
        #1 check("R1", int'(serve_o), 1);
        done(2'd1, 1'b1);
        tick();
        #1 check("R2", int'(serve_o), 2);
        done(2'd2, 1'b1);
        tick();
        #1 check("R4", int'(serve_o), 1);

        // R2: run lengths for every ratio
        for (int r = 0; r < 4; r++) begin
            cur_req = "R2";
            ratio_i = 2'(r);
            // align: serve until bulk is chosen, then measure
            for (int k = 0; k < 12; k++) begin
                #1 s = int'(serve_o);
                done(2'(s), 1'b1);
                tick();
                if (s == 2) break;
            end
            run = 0;
            for (int k = 0; k < 12; k++) begin
                #1 s = int'(serve_o);
                done(2'(s), 1'b1);
                tick();
                if (s == 2) break;
                run++;
            end
            check("R2", run, r + 1);
        end

        // R3: empty control descriptors do not count (ratio 1)
        cur_req = "R3";
        ratio_i = 2'd1;
        for (int k = 0; k < 5; k++) begin
            done(2'd1, 1'b0);
            tick();
        end
        #1 check("R3", int'(serve_o), 1);
        done(2'd1, 1'b1);
        tick();
        #1 check("R3", int'(serve_o), 1);
        // R5: count kept over start of frame
        cur_req = "R5";
        sof_i = 1'b1;
        tick();
        done(2'd1, 1'b1);
        tick();
        #1 check("R5", int'(serve_o), 2);
        // R10: ctrl fallback while bulk preferred does not advance
        cur_req = "R10";
        bulk_work_i = 1'b0;
        #1 check("R7", int'(serve_o), 1);
        done(2'd1, 1'b1);
        tick();
        bulk_work_i = 1'b1;
        #1 check("R10", int'(serve_o), 2);
        // R8: periodic/idle kinds do not touch the count
        cur_req = "R8";
        done(2'd3, 1'b1);
        tick();
        done(2'd0, 1'b1);
        tick();
        #1 check("R8", int'(serve_o), 2);
        done(2'd2, 1'b1);
        tick();
        #1 check("R4", int'(serve_o), 1);
        // R10: bulk fallback while control preferred leaves count alone
        cur_req = "R10";
        done(2'd1, 1'b1);
        tick();
        ctrl_work_i = 1'b0;
        #1 check("R7", int'(serve_o), 2);
        done(2'd2, 1'b1);
        tick();
        ctrl_work_i = 1'b1;
        done(2'd1, 1'b1);
        tick();
        #1 check("R10", int'(serve_o), 2);
        // R7: nothing to do -> idle
        cur_req = "R7";
        ctrl_work_i = 1'b0;
        bulk_work_i = 1'b0;
        #1 check("R7", int'(serve_o), 0);
        tick();

        // R6: periodic enable captured only at start of frame
        cur_req = "R6";
        periodic_work_i = 1'b1;
        ctrl_work_i = 1'b1;
        periodic_en_i = 1'b1;
        tick();
        tick();
        #1 check("R6", int'(serve_o) == 3 ? 1 : 0, 0);
        sof_i = 1'b1;
        tick();
        #1 check("R6", int'(serve_o), 3);
        periodic_en_i = 1'b0;
        tick();
        #1 check("R6", int'(serve_o), 3);
        periodic_work_i = 1'b0;
        #1 check("R6", int'(serve_o) == 3 ? 1 : 0, 0);
        periodic_work_i = 1'b1;
        sof_i = 1'b1;
        tick();
        #1 check("R6", int'(serve_o) == 3 ? 1 : 0, 0);

        // R9: mixed random traffic, all codes, checked every clock
        cur_req = "R9";
        for (int k = 0; k < 3000; k++) begin
            sof_i = ($urandom_range(15) == 0);
            periodic_en_i = $urandom_range(1);
            if ($urandom_range(63) == 0) ratio_i = 2'($urandom_range(3));
            ed_done_i = $urandom_range(1);
            ed_kind_i = 2'($urandom_range(3));
            ed_nonempty_i = ($urandom_range(3) != 0);
            ctrl_work_i = ($urandom_range(3) != 0);
            bulk_work_i = ($urandom_range(3) != 0);
            periodic_work_i = $urandom_range(1);
            @(posedge clk);
            #1;
        end
        ed_done_i = 1'b0;
        sof_i = 1'b0;
        tick();
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule